// File: doc/BRIEF.md
# Output Fault Qualifier and Status Latch

This block sits between the per-channel fault comparators of a multi-channel low-side driver and the serial status frame that a host reads. For every output channel it forms a raw fault condition from three sources: an open-load flag that only counts while the channel is commanded off and its open-load test current is enabled, a short or over-current flag that only counts while the channel is commanded on, and an over-temperature flag that counts in either state. A raw condition must persist for a programmable number of time ticks before it is accepted.

Accepted faults are held in sticky bits until the next chip-select rising edge, which also restarts every persistence timer so that comparators settling after an output change cannot raise a false fault. An over-voltage flag is latched the same way, and an any-fault summary bit is kept alongside. On a chip-select falling edge the held status is copied into a status word laid out for the serial shifter: summary bit on top, over-voltage next, six zero bits, then one bit per channel with channel 0 at the bottom.

Top module: `drv_fault_qual`

## Requirements
- R1: While `rst` is high, and on the first sample after it falls, `fault_q`, `ov_q`, `any_q` and `snap_word` are all zero.
- R2: An open-load flag on channel i sets `fault_q[i]` only while `gate_on[i]` is 0 and `ol_en[i]` is 1.
- R3: An open-load flag on a channel with `gate_on` at 1, or with `ol_en` at 0, never sets its fault bit.
- R4: A short flag on channel i sets `fault_q[i]` only while `gate_on[i]` is 1.
- R5: An over-temperature flag on channel i sets `fault_q[i]` whatever the state of `gate_on[i]` and `ol_en[i]`.
- R6: A raw condition held for (DELAY_TICKS-1)*CLK_PER_TICK cycles leaves its bit clear; held for (DELAY_TICKS+1)*CLK_PER_TICK+2 cycles it sets it; a one-cycle gap in the condition restarts the count.
- R7: A pulse on `cs_rise` restarts every channel's persistence count, so a condition that spans it needs the full delay again after it.
- R8: A set fault bit stays set after its raw condition goes away, until a `cs_rise` pulse clears it.
- R9: A channel whose condition is qualified in the same cycle as a `cs_rise` pulse keeps its fault bit set after that pulse.
- R10: A one-cycle `ovolt_raw` pulse sets `ov_q` on the next cycle; it stays set until a `cs_rise` pulse while `ovolt_raw` is low.
- R11: `any_q` is 1 exactly when some bit of `fault_q` or `ov_q` is 1.
- R12: The cycle after a `cs_fall` pulse, `snap_word` equals {any_q, ov_q, six zero bits, fault_q} as held before that pulse, with channel 0 at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_rise | input | 1 | One-cycle strobe at chip-select rising edge: clears status, restarts timers |
| cs_fall | input | 1 | One-cycle strobe at chip-select falling edge: captures status word |
| gate_on | input | NCH | Commanded gate state per channel, 1 = on |
| ol_en | input | NCH | Open-load test current enable per channel |
| ol_raw | input | NCH | Raw open-load comparator flags |
| short_raw | input | NCH | Raw short / over-current flags |
| otemp_raw | input | NCH | Raw over-temperature flags |
| ovolt_raw | input | 1 | Raw supply over-voltage flag |
| fault_q | output | NCH | Sticky per-channel fault bits |
| ov_q | output | 1 | Sticky over-voltage bit |
| any_q | output | 1 | Any-fault summary |
| snap_word | output | NCH+8 | Status word captured for the serial shifter |

## Verification
The bench builds the block with four channels, a three-cycle tick and a four-tick delay, so a full persistence window is a dozen cycles and every combination of channel, fault source, gate state and open-load enable can be swept one by one. The short window puts the exact edges of the delay, the restart by chip select, the coincidence of a qualification with a clear, and the snapshot format within a few cycles of each stimulus, where the expected bit pattern is just a shifted one.

// File: rtl/drv_fault_pkg.sv
package drv_fault_pkg;
  // zero bits between the over-voltage bit and the channel bits of the status word
  localparam int unsigned PAD_W = 6;
  localparam int unsigned HDR_W = PAD_W + 2;

  typedef enum logic [1:0] {
    SRC_OPEN  = 2'd0,
    SRC_SHORT = 2'd1,
    SRC_HOT   = 2'd2
  } fault_src_e;
endpackage

// File: rtl/drv_tick_gen.sv
module drv_tick_gen #(
  parameter int unsigned CLK_PER_TICK = 3
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (CLK_PER_TICK <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(CLK_PER_TICK);
      localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/drv_persist.sv
module drv_persist #(
  parameter int unsigned DELAY_TICKS = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  input  logic cond,
  output logic qual
);
  localparam int unsigned CW = $clog2(DELAY_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(DELAY_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart || !cond) cnt <= '0;
    else if (tick && cnt != FULL) cnt <= cnt + 1'b1;
  end

  assign qual = cond && (cnt == FULL);
endmodule

// File: rtl/drv_status_latch.sv
module drv_status_latch
  import drv_fault_pkg::*;
#(
  parameter int unsigned NCH = 16,
  localparam int unsigned FW = NCH + HDR_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_rise,
  input  logic           cs_fall,
  input  logic [NCH-1:0] qual,
  input  logic           ov_in,
  output logic [NCH-1:0] fault_q,
  output logic           ov_q,
  output logic           any_q,
  output logic [FW-1:0]  snap_word
);
  logic [NCH-1:0] fault_nx;
  logic           ov_nx;

  // clear drops only what was held; anything qualifying now survives it
  always_comb begin
    fault_nx = (cs_rise ? '0 : fault_q) | qual;
    ov_nx    = (cs_rise ? 1'b0 : ov_q) | ov_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q   <= '0;
      ov_q      <= 1'b0;
      any_q     <= 1'b0;
      snap_word <= '0;
    end else begin
      fault_q <= fault_nx;
      ov_q    <= ov_nx;
      any_q   <= (|fault_nx) | ov_nx;
      if (cs_fall) snap_word <= {any_q, ov_q, {PAD_W{1'b0}}, fault_q};
    end
  end
endmodule

// File: rtl/drv_fault_qual.sv
module drv_fault_qual
  import drv_fault_pkg::*;
#(
  parameter int unsigned NCH          = 16,
  parameter int unsigned CLK_PER_TICK = 100,
  parameter int unsigned DELAY_TICKS  = 300,
  localparam int unsigned FW = NCH + HDR_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_rise,
  input  logic           cs_fall,
  input  logic [NCH-1:0] gate_on,
  input  logic [NCH-1:0] ol_en,
  input  logic [NCH-1:0] ol_raw,
  input  logic [NCH-1:0] short_raw,
  input  logic [NCH-1:0] otemp_raw,
  input  logic           ovolt_raw,
  output logic [NCH-1:0] fault_q,
  output logic           ov_q,
  output logic           any_q,
  output logic [FW-1:0]  snap_word
);
  logic           tick;
  logic [NCH-1:0] cond;
  logic [NCH-1:0] qual;

  drv_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      // open load counts only when off and test current on; short only when on
      assign cond[i] = otemp_raw[i]
                     | (gate_on[i] & short_raw[i])
                     | (~gate_on[i] & ol_en[i] & ol_raw[i]);
      drv_persist #(.DELAY_TICKS(DELAY_TICKS)) u_persist (
        .clk(clk), .rst(rst), .tick(tick), .restart(cs_rise),
        .cond(cond[i]), .qual(qual[i])
      );
    end
  endgenerate

  drv_status_latch #(.NCH(NCH)) u_latch (
    .clk(clk), .rst(rst), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .qual(qual), .ov_in(ovolt_raw),
    .fault_q(fault_q), .ov_q(ov_q), .any_q(any_q), .snap_word(snap_word)
  );
endmodule

// File: rtl/drv_fault_qual_chk.sv
module drv_fault_qual_chk #(
  parameter int unsigned NCH = 16,
  localparam int unsigned FW = NCH + 8
) (
  input logic           clk,
  input logic           rst,
  input logic           cs_rise,
  input logic           cs_fall,
  input logic           ovolt_raw,
  input logic [NCH-1:0] fault_q,
  input logic           ov_q,
  input logic           any_q,
  input logic [FW-1:0]  snap_word
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (fault_q == '0 && !ov_q && !any_q && snap_word == '0));

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !cs_rise |=> ((fault_q & $past(fault_q)) == $past(fault_q)));

  p_ov_set_r10: assert property (@(posedge clk) disable iff (rst)
    ovolt_raw |=> ov_q);

  p_ov_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (ov_q && !cs_rise) |=> ov_q);

  p_any_r11: assert property (@(posedge clk) disable iff (rst)
    any_q == ((|fault_q) || ov_q));

  p_snap_r12: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> (snap_word[NCH-1:0] == $past(fault_q)
                 && snap_word[FW-1] == $past(any_q)
                 && snap_word[FW-2] == $past(ov_q)
                 && snap_word[FW-3:NCH] == '0));

  p_snap_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !cs_fall |=> $stable(snap_word));
endmodule

bind drv_fault_qual drv_fault_qual_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .cs_rise(cs_rise), .cs_fall(cs_fall),
  .ovolt_raw(ovolt_raw), .fault_q(fault_q), .ov_q(ov_q), .any_q(any_q),
  .snap_word(snap_word)
);

// File: tb/drv_fault_qual_tb.sv
`timescale 1ns/1ps
module drv_fault_qual_tb;
  localparam int NCH = 4;
  localparam int CPT = 3;
  localparam int DLY = 4;
  localparam int FW  = NCH + 8;
  localparam int T_SHORT = (DLY - 1) * CPT;
  localparam int T_LONG  = (DLY + 1) * CPT + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_rise = 1'b0, cs_fall = 1'b0, ovolt_raw = 1'b0;
  logic [NCH-1:0] gate_on = '0, ol_en = '0, ol_raw = '0, short_raw = '0, otemp_raw = '0;
  logic [NCH-1:0] fault_q;
  logic ov_q, any_q;
  logic [FW-1:0] snap_word;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  drv_fault_qual #(.NCH(NCH), .CLK_PER_TICK(CPT), .DELAY_TICKS(DLY)) u_dut (
    .clk(clk), .rst(rst), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .gate_on(gate_on), .ol_en(ol_en), .ol_raw(ol_raw), .short_raw(short_raw),
    .otemp_raw(otemp_raw), .ovolt_raw(ovolt_raw),
    .fault_q(fault_q), .ov_q(ov_q), .any_q(any_q), .snap_word(snap_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rise();
    cs_rise = 1'b1; cyc(1); cs_rise = 1'b0;
  endtask

  task automatic pulse_fall();
    cs_fall = 1'b1; cyc(1); cs_fall = 1'b0;
  endtask

  task automatic raw_off();
    ol_raw = '0; short_raw = '0; otemp_raw = '0;
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NCH-1:0] one;
    logic e;
    cyc(3);
    chk("R1 fault in reset", 32'(fault_q), 0);
    rst = 1'b0;
    cyc(1);
    chk("R1 fault after reset", 32'(fault_q), 0);
    chk("R1 ov/any after reset", {30'd0, ov_q, any_q}, 0);
    chk("R1 snap after reset", 32'(snap_word), 0);

    // sweep: channel x source x gate x open-load enable
    for (int ch = 0; ch < NCH; ch++)
      for (int src = 0; src < 3; src++)
        for (int g = 0; g < 2; g++)
          for (int oe = 0; oe < 2; oe++) begin
            one = NCH'(1) << ch;
            gate_on = g[0] ? one : '0;
            ol_en   = oe[0] ? one : '0;
            raw_off();
            pulse_rise();
            case (src)
              0: begin ol_raw = one;    e = (g == 0) && (oe == 1); end // R2 R3
              1: begin short_raw = one; e = (g == 1); end             // R4
              default: begin otemp_raw = one; e = 1'b1; end         // R5
            endcase
            cyc(T_LONG);
            chk(src == 0 ? "R2/R3 open-load gating" : (src == 1 ? "R4 short gating" : "R5 over-temp"),
                32'(fault_q), e ? 32'(one) : 0);
            chk("R11 any follows fault", 32'(any_q), 32'(e));
            raw_off();
            cyc(5);
            chk("R8 sticky after condition gone", 32'(fault_q), e ? 32'(one) : 0);
            pulse_fall();
            chk("R12 snapshot word", 32'(snap_word),
                32'({e, 1'b0, 6'b0, (e ? one : NCH'(0))}));
            pulse_rise();
            chk("R8 cleared by cs rise", 32'(fault_q), 0);
            chk("R11 any clear", 32'(any_q), 0);
          end

    // R6: delay edges
    gate_on = '0; ol_en = '0; raw_off(); pulse_rise();
    otemp_raw = 4'b0100;
    cyc(T_SHORT);
    chk("R6 not set before delay", 32'(fault_q), 0);
    cyc(T_LONG - T_SHORT);
    chk("R6 set after delay", 32'(fault_q), 32'h4);
    raw_off(); pulse_rise();
    otemp_raw = 4'b0010; cyc(T_SHORT);
    otemp_raw = '0;      cyc(1);
    otemp_raw = 4'b0010; cyc(T_SHORT);
    chk("R6 gap restarts count", 32'(fault_q), 0);
    cyc(T_LONG);
    chk("R6 set after restart", 32'(fault_q), 32'h2);
    raw_off(); pulse_rise();

    // R7: cs rise restarts persistence
    short_raw = 4'b1000; gate_on = 4'b1000;
    cyc(T_SHORT);
    pulse_rise();
    cyc(T_SHORT - 1);
    chk("R7 cs rise restarts timer", 32'(fault_q), 0);
    cyc(T_LONG);
    chk("R7 set after full delay", 32'(fault_q), 32'h8);

    // R9: qualified at the clear cycle survives it
    pulse_rise();
    chk("R9 fault kept across clear", 32'(fault_q), 32'h8);
    raw_off(); gate_on = '0;
    pulse_rise();
    chk("R9 then clears", 32'(fault_q), 0);

    // R10/R11/R12: over-voltage
    ovolt_raw = 1'b1; cyc(1); ovolt_raw = 1'b0;
    chk("R10 ov set", 32'(ov_q), 1);
    chk("R11 any from ov", 32'(any_q), 1);
    cyc(6);
    chk("R10 ov sticky", 32'(ov_q), 1);
    pulse_fall();
    chk("R12 snapshot ov", 32'(snap_word), 32'({1'b1, 1'b1, 6'b0, 4'b0}));
    pulse_rise();
    chk("R10 ov cleared", 32'(ov_q), 0);
    chk("R11 any cleared", 32'(any_q), 0);
    chk("R12 snapshot held", 32'(snap_word), 32'({1'b1, 1'b1, 6'b0, 4'b0}));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule